// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block collects 32 peripheral interrupt lines and turns them into one request towards a processor core. Software reaches it through a word-addressed register port. Each line has an enable bit, a pending bit and a small priority level, and the block keeps track of which lines are currently being serviced. Each enable bit and each pending bit has one register that sets it and another that clears it. Writing a 1 to a bit position acts on that line, and writing a 0 leaves it alone.

The arbiter looks at every line that is enabled, pending and not already being serviced. It picks the most urgent one and compares it with the handler that is currently running. When the new line may preempt, the block raises a request. With that request it presents the exception number and the word address in the vector table where the handler entry is fetched. The core answers with an acknowledge when it takes the interrupt, and with a return pulse when the handler finishes. Nested handlers are unwound in reverse order of entry.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Word 0 sets enable bits and word 1 clears them. A 1 in bit n acts on line n and a 0 has no effect. Reading either word returns the enable vector.
- R2: Word 2 sets pending bits and word 3 clears them, with the same per-bit rule. Reading either word returns the pending vector.
- R3: Line n's priority lives in word 8 + n/4, in byte n%4 (bits 8·(n%4)+7 down to 8·(n%4)). Only the top 2 bits of each byte are kept. The lower 6 bits read as zero and ignore writes. All priorities reset to 0.
- R4: Lines 8 to 15 are edge-sensitive: a rising input sets pending, even while the line is active. All other lines are level-sensitive: a high input sets pending only while the line is not active.
- R5: A pending line whose enable bit is clear never raises a request and is never made active.
- R6: Among enabled, pending, non-active lines, the lowest priority value wins. A tie goes to the lowest line number.
- R7: The request is raised only when the winner's priority value is strictly below that of the innermost running handler. With no handler running, any winner is requested.
- R8: The exception number equals the line number plus 16, and the vector address equals the exception number times 4.
- R9: On an acknowledge while a request is raised, the chosen line's pending bit clears and its active bit sets in the same cycle. A return pulse clears the active bit of the most recently entered line.
- R10: Clearing the enable or pending bit of an active line does not end its active state.
- R11: A level line whose input is still high when its handler returns becomes pending again one cycle after the return.
- R12: Synchronous reset clears all enable, pending and active state and drops the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt lines from peripherals |
| reg_addr | input | 4 | Word index for register read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | output | 1 | Interrupt request to the core |
| irq_excnum | output | 8 | Exception number of the requested line |
| irq_vec_addr | output | 32 | Vector-table fetch address |
| irq_ack | input | 1 | Core takes the requested interrupt |
| exc_ret | input | 1 | Core finishes the innermost handler |

## Verification
The bench targets four kinds of failure:
- **Ties and preemption.** It builds equal-priority ties and a strict-preemption case. A design that compared with less-or-equal would re-enter a handler of the same level, and one that broke ties the wrong way would name the higher line.
- **Active state surviving clears.** It clears the enable and pending bits of a running line and checks that no same-level line slips in. That would happen if the active state were dropped with the enable.
- **Nested unwinding.** It nests two handlers and returns one at a time. A design that popped the oldest entry would expose the wrong running level.
- **Edge and level capture.** A level line held high is checked not to re-pend while active and to re-pend exactly one cycle after return. An edge line is checked to re-pend on a new rising edge during its own handler.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    localparam int NUM_LINES = 32;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int PRIO_BITS = 2;
    localparam int LVL_W     = PRIO_BITS + 1;
    localparam int NEST_MAX  = 2 ** PRIO_BITS;
    localparam int SP_W      = $clog2(NEST_MAX + 1);
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int EXC_OFS   = 16;
    localparam int PRIO_BASE = 8;
    localparam int PRIO_REGS = NUM_LINES / 4;

    typedef logic [LINE_W-1:0] line_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    localparam lvl_t IDLE_LVL = lvl_t'(NEST_MAX);

    typedef enum logic [ADDR_W-1:0] {
        RA_EN_SET   = 4'd0,
        RA_EN_CLR   = 4'd1,
        RA_PEND_SET = 4'd2,
        RA_PEND_CLR = 4'd3
    } reg_sel_t;

    typedef struct packed {
        logic  vld;
        line_t line;
        lvl_t  lvl;
    } cand_t;

    function automatic logic [7:0] exc_num(input line_t l);
        return 8'(l) + 8'(EXC_OFS);
    endfunction

    function automatic logic [31:0] vec_addr(input logic [7:0] exc);
        return {22'b0, exc, 2'b00};
    endfunction

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
    import prio_irq_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] EDGE_LINES = 32'h0000_FF00
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_LINES-1:0]                irq_in,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                ack_take,
    input  line_t                               ack_line,
    input  logic [NUM_LINES-1:0]                act,
    output logic [NUM_LINES-1:0]                en_q,
    output logic [NUM_LINES-1:0]                pend_q,
    output logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio_q,
    output logic [DATA_W-1:0]                   rd_data
);

    logic wr_en_set, wr_en_clr, wr_pd_set, wr_pd_clr;

    always_comb begin
        wr_en_set = wr_en && (addr == RA_EN_SET);
        wr_en_clr = wr_en && (addr == RA_EN_CLR);
        wr_pd_set = wr_en && (addr == RA_PEND_SET);
        wr_pd_clr = wr_en && (addr == RA_PEND_CLR);
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam int          PWORD = PRIO_BASE + g / 4;
        localparam int          PHI   = (g % 4) * 8 + 7;
        localparam logic        IS_EDGE = EDGE_LINES[g];
        logic prev_q;
        logic hw_set, clr_now, set_now;

        always_comb begin
            if (IS_EDGE) hw_set = irq_in[g] && !prev_q;
            else         hw_set = irq_in[g] && !act[g] && !(ack_take && ack_line == line_t'(g));
            clr_now = (wr_pd_clr && wr_data[g]) || (ack_take && ack_line == line_t'(g));
            set_now = (wr_pd_set && wr_data[g]) || hw_set;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q    <= 1'b0;
                en_q[g]   <= 1'b0;
                pend_q[g] <= 1'b0;
                prio_q[g] <= '0;
            end else begin
                prev_q <= irq_in[g];
                if (wr_en_set && wr_data[g])      en_q[g] <= 1'b1;
                else if (wr_en_clr && wr_data[g]) en_q[g] <= 1'b0;
                pend_q[g] <= (pend_q[g] && !clr_now) || set_now;
                if (wr_en && addr == ADDR_W'(PWORD))
                    prio_q[g] <= wr_data[PHI -: PRIO_BITS];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            RA_EN_SET,   RA_EN_CLR:   rd_data = en_q;
            RA_PEND_SET, RA_PEND_CLR: rd_data = pend_q;
            default: begin
                for (int k = 0; k < PRIO_REGS; k++) begin
                    if (addr == ADDR_W'(PRIO_BASE + k)) begin
                        for (int b = 0; b < 4; b++)
                            rd_data[b*8 +: 8] = {prio_q[k*4+b], {(8-PRIO_BITS){1'b0}}};
                    end
                end
            end
        endcase
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import prio_irq_pkg::*;
(
    input  logic [NUM_LINES-1:0]                en,
    input  logic [NUM_LINES-1:0]                pend,
    input  logic [NUM_LINES-1:0]                act,
    input  logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio,
    output cand_t                               best
);

    always_comb begin
        best = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (en[i] && pend[i] && !act[i] &&
                (!best.vld || lvl_t'(prio[i]) < best.lvl)) begin
                best.vld  = 1'b1;
                best.line = line_t'(i);
                best.lvl  = lvl_t'(prio[i]);
            end
        end
    end

endmodule

// File: rtl/irq_nest.sv
module irq_nest
    import prio_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 push,
    input  line_t                push_line,
    input  lvl_t                 push_lvl,
    input  logic                 pop,
    output logic [NUM_LINES-1:0] act_q,
    output lvl_t                 run_lvl
);

    line_t           stk_line [NEST_MAX];
    lvl_t            stk_lvl  [NEST_MAX];
    logic [SP_W-1:0] sp;

    always_comb begin
        if (sp == '0) run_lvl = IDLE_LVL;
        else          run_lvl = stk_lvl[sp - 1'b1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp    <= '0;
            act_q <= '0;
            for (int i = 0; i < NEST_MAX; i++) begin
                stk_line[i] <= '0;
                stk_lvl[i]  <= '0;
            end
        end else if (pop) begin
            if (sp != '0) begin
                act_q[stk_line[sp - 1'b1]] <= 1'b0;
                sp <= sp - 1'b1;
            end
        end else if (push && sp != SP_W'(NEST_MAX)) begin
            stk_line[sp]     <= push_line;
            stk_lvl[sp]      <= push_lvl;
            act_q[push_line] <= 1'b1;
            sp <= sp + 1'b1;
        end
    end

    AST_NEST_BOUND: assert property (@(posedge clk) disable iff (rst)
        $countones(act_q) <= NEST_MAX); // R7

    AST_RET_DROPS_ONE: assert property (@(posedge clk) disable iff (rst)
        (pop && sp != '0) |=> ($countones($past(act_q) & ~act_q) == 1)); // R9

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter logic [NUM_LINES-1:0] EDGE_LINES = 32'h0000_FF00
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_req,
    output logic [7:0]           irq_excnum,
    output logic [31:0]          irq_vec_addr,
    input  logic                 irq_ack,
    input  logic                 exc_ret
);

    logic [NUM_LINES-1:0]                en, pend, act;
    logic [NUM_LINES-1:0][PRIO_BITS-1:0] prio;
    cand_t best;
    lvl_t  run_lvl;
    logic  ack_take;

    irq_line_bank #(.EDGE_LINES(EDGE_LINES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .ack_take (ack_take),
        .ack_line (best.line),
        .act      (act),
        .en_q     (en),
        .pend_q   (pend),
        .prio_q   (prio),
        .rd_data  (reg_rdata)
    );

    irq_pick u_pick (
        .en   (en),
        .pend (pend),
        .act  (act),
        .prio (prio),
        .best (best)
    );

    irq_nest u_nest (
        .clk       (clk),
        .rst       (rst),
        .push      (ack_take),
        .push_line (best.line),
        .push_lvl  (best.lvl),
        .pop       (exc_ret),
        .act_q     (act),
        .run_lvl   (run_lvl)
    );

    always_comb begin
        irq_req      = best.vld && (best.lvl < run_lvl);
        ack_take     = irq_ack && irq_req && !exc_ret;
        irq_excnum   = exc_num(best.line);
        irq_vec_addr = vec_addr(irq_excnum);
    end

    AST_DISABLED_NOT_ACTIVATED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((act & ~$past(act) & ~$past(en)) == '0)); // R5

    AST_SINGLE_ACTIVATION: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $onehot0(act & ~$past(act))); // R9

    AST_CLEAR_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !exc_ret && (reg_addr == RA_EN_CLR || reg_addr == RA_PEND_CLR))
        |=> (($past(act) & ~act) == '0)); // R10

    AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec_addr >= 32'h40 && irq_vec_addr[1:0] == 2'b00)); // R8

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_req;
    logic [7:0]  irq_excnum;
    logic [31:0] irq_vec_addr;
    logic        irq_ack = 1'b0;
    logic        exc_ret = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_req(irq_req), .irq_excnum(irq_excnum), .irq_vec_addr(irq_vec_addr),
        .irq_ack(irq_ack), .exc_ret(exc_ret)
    );

    // row: {write addr, write data, read addr, expected read, requirement}
    localparam int NROWS = 10;
    localparam logic [75:0] TBL [NROWS] = '{
        {4'd0, 32'h0000_00F0, 4'd1, 32'h0000_00F0, 4'd1},  // R1 set
        {4'd1, 32'h0000_0030, 4'd0, 32'h0000_00C0, 4'd1},  // R1 clear
        {4'd0, 32'h0000_0000, 4'd1, 32'h0000_00C0, 4'd1},  // R1 zero no effect
        {4'd9, 32'hFFFF_FFFF, 4'd9, 32'hC0C0_C0C0, 4'd3},  // R3 low bits dropped
        {4'd9, 32'h4080_003F, 4'd9, 32'h4080_0000, 4'd3},  // R3 per-byte
        {4'd2, 32'h0000_0003, 4'd3, 32'h0000_0003, 4'd2},  // R2 set
        {4'd3, 32'h0000_0001, 4'd2, 32'h0000_0002, 4'd2},  // R2 clear
        {4'd2, 32'h0000_0000, 4'd3, 32'h0000_0002, 4'd2},  // R2 zero no effect
        {4'd3, 32'hFFFF_FFFF, 4'd2, 32'h0000_0000, 4'd2},  // R2 clear all
        {4'd1, 32'hFFFF_FFFF, 4'd0, 32'h0000_0000, 4'd1}   // R1 clear all
    };

    task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        exc_ret = 1'b1;
        @(negedge clk);
        exc_ret = 1'b0;
    endtask

    task automatic chk_req(input string tag, input logic exp_req, input logic [7:0] exp_exc);
        chk({tag, " req"}, {31'b0, irq_req}, {31'b0, exp_req});
        if (exp_req) begin
            chk({tag, " exc"}, {24'b0, irq_excnum}, {24'b0, exp_exc});
            chk({tag, " vec"}, irq_vec_addr, {22'b0, exp_exc, 2'b00});
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        do_reset();

        // R12 reset state
        chk_req("R12 reset", 1'b0, 8'd0);
        rd(4'd0, v); chk("R12 enable", v, 32'h0);
        rd(4'd2, v); chk("R12 pending", v, 32'h0);
        rd(4'd8, v); chk("R12 priority", v, 32'h0);

        for (int i = 0; i < NROWS; i++) begin
            wr(TBL[i][75:72], TBL[i][71:40]);
            rd(TBL[i][39:36], v);
            chk($sformatf("R%0d row %0d", TBL[i][3:0], i), v, TBL[i][35:4]);
        end

        do_reset();
        for (int k = 8; k < 16; k++) wr(4'(k), 32'hC0C0_C0C0);
        wr(4'd8,  32'h40C0_C0C0);   // line 3 level 1
        wr(4'd12, 32'h40C0_C0C0);   // line 19 level 1
        wr(4'd9,  32'hC0C0_80C0);   // line 5 level 2
        wr(4'd0,  32'h0008_0028);   // enable 3, 5, 19

        wr(4'd2, 32'h0000_0020);
        chk_req("R8 line5", 1'b1, 8'd21);
        wr(4'd2, 32'h0008_0000);
        chk_req("R6 lower level wins", 1'b1, 8'd35);
        wr(4'd2, 32'h0000_0008);
        chk_req("R6 tie lowest line", 1'b1, 8'd19);

        ack();
        rd(4'd2, v); chk("R9 ack clears pending", v, 32'h0008_0020);
        chk_req("R7 equal level blocked", 1'b0, 8'd0);

        wr(4'd1, 32'h0000_0008);
        wr(4'd3, 32'h0000_0008);
        chk_req("R10 active kept", 1'b0, 8'd0);
        rd(4'd0, v); chk("R10 enable cleared", v, 32'h0008_0020);

        ret();
        chk_req("R9 return frees level", 1'b1, 8'd35);

        ack();                      // line 19 running
        chk_req("R7 after ack", 1'b0, 8'd0);
        wr(4'd8, 32'h40C0_C000);    // line 0 level 0
        wr(4'd0, 32'h0000_0001);
        wr(4'd2, 32'h0000_0001);
        chk_req("R7 strict preempt", 1'b1, 8'd16);
        ack();                      // nest: 19 then 0
        chk_req("R7 nested", 1'b0, 8'd0);
        ret();
        chk_req("R9 pop innermost", 1'b0, 8'd0);
        ret();
        chk_req("R9 pop outer", 1'b1, 8'd21);
        ack();
        ret();
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd3, 32'hFFFF_FFFF);

        // R5 disabled line collects pending but no request
        wr(4'd2, 32'h0000_0010);
        chk_req("R5 disabled", 1'b0, 8'd0);
        rd(4'd3, v); chk("R5 pending kept", v, 32'h0000_0010);
        wr(4'd0, 32'h0000_0010);
        chk_req("R5 enabled", 1'b1, 8'd20);
        wr(4'd1, 32'h0000_0010);
        wr(4'd3, 32'h0000_0010);

        // level line 20
        wr(4'd0, 32'h0010_0000);
        irq_in[20] = 1'b1;
        @(negedge clk);
        rd(4'd2, v); chk("R4 level pends", v, 32'h0010_0000);
        chk_req("R4 level req", 1'b1, 8'd36);
        ack();
        rd(4'd2, v); chk("R4 level no pend while active", v, 32'h0);
        ret();
        rd(4'd2, v); chk("R11 not yet", v, 32'h0);
        @(negedge clk);
        rd(4'd2, v); chk("R11 re-pend", v, 32'h0010_0000);
        chk_req("R11 req", 1'b1, 8'd36);
        irq_in[20] = 1'b0;
        wr(4'd3, 32'h0010_0000);
        wr(4'd1, 32'h0010_0000);

        // edge line 10
        wr(4'd0, 32'h0000_0400);
        irq_in[10] = 1'b1;
        @(negedge clk);
        rd(4'd2, v); chk("R4 edge pends", v, 32'h0000_0400);
        chk_req("R4 edge req", 1'b1, 8'd26);
        ack();
        @(negedge clk);
        rd(4'd2, v); chk("R4 edge held no pend", v, 32'h0);
        irq_in[10] = 1'b0;
        @(negedge clk);
        irq_in[10] = 1'b1;
        @(negedge clk);
        rd(4'd2, v); chk("R4 edge while active", v, 32'h0000_0400);
        chk_req("R4 edge active blocked", 1'b0, 8'd0);
        ret();
        chk_req("R9 edge after return", 1'b1, 8'd26);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule